// File: doc/BRIEF.md
# Oversampling Asynchronous Serial Receiver

This block turns an asynchronous serial line into characters for a processor. The line is sampled on a tick that runs at sixteen times the bit rate. A falling level on an idle line starts a frame. The receiver then reads eight or nine data bits, least significant bit first, and checks the stop bit. Each bit is decided by a majority vote of three samples taken near its centre.

A finished character moves into a holding buffer, where it waits for the processor. The next character can be shifted in while the buffer still holds the previous one. Status outputs report the following conditions:
- a character waiting in the buffer,
- a character lost to overrun,
- disagreeing samples within a bit,
- a bad stop bit,
- a line that has gone quiet after traffic.

The processor clears the flags with a status-read strobe followed by a data-read strobe. The line input is assumed to be already synchronous to the clock.

Top module: `os_serial_rx`

## Requirements
- R1: While the receiver is hunting, the first tick that sees the line at 0 is bit tick 0 of a start bit. If the vote taken at tick 9 of that bit gives 1, the start is dropped as a glitch and hunting resumes. Nothing is loaded and no flag changes.
- R2: Each bit lasts 16 ticks. The line is sampled on ticks 7, 8 and 9 of the bit, and the bit value is the majority of those three samples. Data bits arrive least significant bit first.
- R3: With `nine_bit_i` at 0 a frame carries 8 data bits, and `bit8_o` is loaded with 0. With `nine_bit_i` at 1 a frame carries 9 data bits, and the ninth bit is loaded into `bit8_o`.
- R4: A character completes at tick 9 of the stop bit. If the buffer is empty, the character is loaded into `data_o`/`bit8_o` and `full_o` rises.
- R5: `noise_o` is loaded as 1 with a character when the three samples of any of its bits (start, data or stop) disagree.
- R6: `frame_err_o` is loaded as 1 with a character whose stop bit votes 0.
- R7: A character that completes while `full_o` is 1 sets `overrun_o`. The new character is discarded and `data_o` keeps the older one.
- R8: After an accepted frame, `idle_o` sets when the line has been at 1 for (data bits + 2) × 16 consecutive ticks. The count starts with the first tick after the stop-bit vote. Idle can be reported at most once per accepted frame.
- R9: A `stat_rd_i` pulse arms the clear. A later `data_rd_i` pulse clears `full_o`, `overrun_o`, `noise_o`, `frame_err_o` and `idle_o`, and uses up the arming. A `data_rd_i` pulse without a prior status read has no effect, and a status read alone has no effect.
- R10: The clear sequence may be performed while the next character is being shifted in. That character is then loaded normally, with no overrun.
- R11: While `rx_en_i` is 0 the receiver stays in hunt and receives nothing. The flags keep their values.
- R12: After reset all flags are 0 and `data_o`/`bit8_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| rxd_i | input | 1 | Serial line, idle high, synchronous to clk_i |
| tick16_i | input | 1 | One-cycle pulse at 16 times the bit rate |
| rx_en_i | input | 1 | Receiver enable |
| nine_bit_i | input | 1 | 1 selects 9 data bits per frame |
| stat_rd_i | input | 1 | Status-read strobe |
| data_rd_i | input | 1 | Data-read strobe |
| data_o | output | 8 | Buffered character, low 8 bits |
| bit8_o | output | 1 | Buffered ninth bit |
| full_o | output | 1 | Character waiting in buffer |
| overrun_o | output | 1 | Character lost because the buffer was full |
| noise_o | output | 1 | Disagreeing samples in the buffered character |
| frame_err_o | output | 1 | Bad stop bit in the buffered character |
| idle_o | output | 1 | Line went idle after traffic |

## Verification
The case hardest to reach from the ports is a disagreement among the three samples of a single bit. On a clean line all three always agree. For this reason the bench produces every tick itself and sets the line level for each tick. This lets it flip exactly tick 8 of a chosen bit, which sits between the two samples that do agree. The same per-tick control is used for two other cases:
- a start pulse short enough to vanish before the mid-start vote,
- an idle check that counts to one tick short of the threshold and then to exactly the threshold.

// File: rtl/os_rx_pkg.sv
package os_rx_pkg;
  typedef enum logic [1:0] {
    ST_HUNT,
    ST_START,
    ST_DATA,
    ST_STOP
  } rx_state_e;

  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction
endpackage

// File: rtl/os_rx_vote.sv
module os_rx_vote
  import os_rx_pkg::*;
#(
  parameter int OSR = 16,
  parameter int CW  = $clog2(OSR)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          line_i,
  input  logic [CW-1:0] cnt_i,
  output logic          bit_o,
  output logic          noisy_o
);
  localparam int NS = 2;  // registered samples; the third is the live line
  localparam int MID = OSR / 2;

  logic [NS-1:0] smp_q;

  for (genvar g = 0; g < NS; g++) begin : g_tap
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) smp_q[g] <= 1'b1;
      else if (tick_i && cnt_i == CW'(MID - 1 + g)) smp_q[g] <= line_i;
    end
  end

  assign bit_o   = maj3(smp_q[0], smp_q[1], line_i);
  assign noisy_o = !((smp_q[0] == smp_q[1]) && (smp_q[1] == line_i));
endmodule

// File: rtl/os_rx_frame.sv
module os_rx_frame
  import os_rx_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int OSR    = 16,
  parameter int CW     = $clog2(OSR)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            en_i,
  input  logic            tick_i,
  input  logic            line_i,
  input  logic            nine_i,
  input  logic            vbit_i,
  input  logic            vnoise_i,
  output logic [CW-1:0]   cnt_o,
  output logic            hunt_o,
  output logic            accept_o,
  output logic            done_o,
  output logic            noise_o,
  output logic            stop_bad_o,
  output logic [DATA_W:0] shreg_o
);
  localparam int IW = $clog2(DATA_W + 1);
  localparam logic [CW-1:0] EVAL = CW'(OSR / 2 + 1);
  localparam logic [CW-1:0] LAST_TICK = CW'(OSR - 1);

  rx_state_e      state_q;
  logic [IW-1:0]  idx_q;
  logic           nacc_q;
  logic           mode9_q;
  logic [IW-1:0]  last_idx;

  assign last_idx = mode9_q ? IW'(DATA_W) : IW'(DATA_W - 1);
  assign hunt_o   = (state_q == ST_HUNT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_HUNT;
      cnt_o      <= '0;
      idx_q      <= '0;
      nacc_q     <= 1'b0;
      mode9_q    <= 1'b0;
      shreg_o    <= '0;
      accept_o   <= 1'b0;
      done_o     <= 1'b0;
      noise_o    <= 1'b0;
      stop_bad_o <= 1'b0;
    end else begin
      accept_o <= 1'b0;
      done_o   <= 1'b0;
      if (!en_i) begin
        state_q <= ST_HUNT;
        cnt_o   <= '0;
      end else if (tick_i) begin
        if (state_q == ST_HUNT) begin
          if (!line_i) begin
            state_q <= ST_START;
            cnt_o   <= CW'(1);
            mode9_q <= nine_i;
          end
        end else begin
          cnt_o <= (cnt_o == LAST_TICK) ? '0 : cnt_o + CW'(1);
          if (cnt_o == EVAL) begin
            unique case (state_q)
              ST_START: begin
                if (vbit_i) begin
                  state_q <= ST_HUNT;  // glitch
                  cnt_o   <= '0;
                end else begin
                  state_q  <= ST_DATA;
                  accept_o <= 1'b1;
                  nacc_q   <= vnoise_i;
                  idx_q    <= '0;
                  shreg_o  <= '0;
                end
              end
              ST_DATA: begin
                if (mode9_q) shreg_o <= {vbit_i, shreg_o[DATA_W:1]};
                else         shreg_o <= {1'b0, vbit_i, shreg_o[DATA_W-1:1]};
                nacc_q <= nacc_q | vnoise_i;
                idx_q  <= idx_q + IW'(1);
                if (idx_q == last_idx) state_q <= ST_STOP;
              end
              ST_STOP: begin
                done_o     <= 1'b1;
                noise_o    <= nacc_q | vnoise_i;
                stop_bad_o <= !vbit_i;
                state_q    <= ST_HUNT;
                cnt_o      <= '0;
              end
              default: state_q <= ST_HUNT;
            endcase
          end
        end
      end
    end
  end
endmodule

// File: rtl/os_rx_idle.sv
module os_rx_idle #(
  parameter int DATA_W = 8,
  parameter int OSR    = 16
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic en_i,
  input  logic tick_i,
  input  logic line_i,
  input  logic nine_i,
  input  logic hunt_i,
  input  logic accept_i,
  output logic idle_set_o
);
  localparam int LIM8 = (DATA_W + 2) * OSR;
  localparam int LIM9 = (DATA_W + 3) * OSR;
  localparam int QW = $clog2(LIM9 + 1);

  logic [QW-1:0] run_q;
  logic          armed_q;
  logic [QW-1:0] limit;

  assign limit = nine_i ? QW'(LIM9) : QW'(LIM8);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q      <= '0;
      armed_q    <= 1'b0;
      idle_set_o <= 1'b0;
    end else begin
      idle_set_o <= 1'b0;
      if (!en_i) begin
        run_q   <= '0;
        armed_q <= 1'b0;
      end else begin
        if (accept_i) armed_q <= 1'b1;
        if (tick_i) begin
          if (!hunt_i || !line_i || !armed_q) begin
            run_q <= '0;
          end else if (run_q + QW'(1) == limit) begin
            run_q      <= '0;
            armed_q    <= 1'b0;
            idle_set_o <= 1'b1;
          end else begin
            run_q <= run_q + QW'(1);
          end
        end
      end
    end
  end
endmodule

// File: rtl/os_rx_hold.sv
module os_rx_hold #(
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              done_i,
  input  logic [DATA_W:0]   char_i,
  input  logic              noise_i,
  input  logic              stop_bad_i,
  input  logic              idle_set_i,
  input  logic              stat_rd_i,
  input  logic              data_rd_i,
  output logic [DATA_W-1:0] data_o,
  output logic              bit8_o,
  output logic              full_o,
  output logic              overrun_o,
  output logic              noise_o,
  output logic              frame_err_o,
  output logic              idle_o
);
  logic rd_armed_q;
  logic clr;
  logic full_eff;

  assign clr      = data_rd_i && rd_armed_q;
  assign full_eff = full_o && !clr;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rd_armed_q  <= 1'b0;
      data_o      <= '0;
      bit8_o      <= 1'b0;
      full_o      <= 1'b0;
      overrun_o   <= 1'b0;
      noise_o     <= 1'b0;
      frame_err_o <= 1'b0;
      idle_o      <= 1'b0;
    end else begin
      if (stat_rd_i) rd_armed_q <= 1'b1;
      if (clr) begin
        rd_armed_q  <= 1'b0;
        full_o      <= 1'b0;
        overrun_o   <= 1'b0;
        noise_o     <= 1'b0;
        frame_err_o <= 1'b0;
        idle_o      <= 1'b0;
      end
      if (idle_set_i) idle_o <= 1'b1;
      if (done_i) begin
        if (full_eff) begin
          overrun_o <= 1'b1;  // keep older character
        end else begin
          data_o      <= char_i[DATA_W-1:0];
          bit8_o      <= char_i[DATA_W];
          full_o      <= 1'b1;
          noise_o     <= noise_i;
          frame_err_o <= stop_bad_i;
        end
      end
    end
  end
endmodule

// File: rtl/os_serial_rx.sv
module os_serial_rx #(
  parameter int DATA_W = 8,
  parameter int OSR    = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              rxd_i,
  input  logic              tick16_i,
  input  logic              rx_en_i,
  input  logic              nine_bit_i,
  input  logic              stat_rd_i,
  input  logic              data_rd_i,
  output logic [DATA_W-1:0] data_o,
  output logic              bit8_o,
  output logic              full_o,
  output logic              overrun_o,
  output logic              noise_o,
  output logic              frame_err_o,
  output logic              idle_o
);
  localparam int CW = $clog2(OSR);

  logic [CW-1:0]   cnt;
  logic            vbit, vnoise;
  logic            hunt, accept, done, f_noise, f_stop_bad, idle_set;
  logic [DATA_W:0] shreg;

  os_rx_vote #(.OSR(OSR), .CW(CW)) u_vote (
    .clk_i, .rst_ni,
    .tick_i (tick16_i),
    .line_i (rxd_i),
    .cnt_i  (cnt),
    .bit_o  (vbit),
    .noisy_o(vnoise)
  );

  os_rx_frame #(.DATA_W(DATA_W), .OSR(OSR), .CW(CW)) u_frame (
    .clk_i, .rst_ni,
    .en_i      (rx_en_i),
    .tick_i    (tick16_i),
    .line_i    (rxd_i),
    .nine_i    (nine_bit_i),
    .vbit_i    (vbit),
    .vnoise_i  (vnoise),
    .cnt_o     (cnt),
    .hunt_o    (hunt),
    .accept_o  (accept),
    .done_o    (done),
    .noise_o   (f_noise),
    .stop_bad_o(f_stop_bad),
    .shreg_o   (shreg)
  );

  os_rx_idle #(.DATA_W(DATA_W), .OSR(OSR)) u_idle (
    .clk_i, .rst_ni,
    .en_i      (rx_en_i),
    .tick_i    (tick16_i),
    .line_i    (rxd_i),
    .nine_i    (nine_bit_i),
    .hunt_i    (hunt),
    .accept_i  (accept),
    .idle_set_o(idle_set)
  );

  os_rx_hold #(.DATA_W(DATA_W)) u_hold (
    .clk_i, .rst_ni,
    .done_i     (done),
    .char_i     (shreg),
    .noise_i    (f_noise),
    .stop_bad_i (f_stop_bad),
    .idle_set_i (idle_set),
    .stat_rd_i,
    .data_rd_i,
    .data_o,
    .bit8_o,
    .full_o,
    .overrun_o,
    .noise_o,
    .frame_err_o,
    .idle_o
  );
endmodule

// File: rtl/os_serial_rx_chk.sv
module os_serial_rx_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              tick16_i,
  input logic              rx_en_i,
  input logic              data_rd_i,
  input logic [DATA_W-1:0] data_o,
  input logic              full_o,
  input logic              overrun_o,
  input logic              noise_o,
  input logic              frame_err_o,
  input logic              idle_o
);
  AST_FULL_FALL_ON_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(full_o) |-> $past(data_rd_i)); // R9

  AST_OVR_WITH_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_o |-> full_o); // R7

  AST_HOLD_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (full_o && $past(full_o)) |-> $stable(data_o)); // R7

  AST_ERR_WITH_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (noise_o || frame_err_o) |-> full_o); // R5

  AST_LOAD_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(full_o) |-> $past(rx_en_i, 2)); // R11

  AST_IDLE_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(idle_o) |-> $past(tick16_i, 2)); // R8
endmodule

bind os_serial_rx os_serial_rx_chk #(.DATA_W(DATA_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .tick16_i   (tick16_i),
  .rx_en_i    (rx_en_i),
  .data_rd_i  (data_rd_i),
  .data_o     (data_o),
  .full_o     (full_o),
  .overrun_o  (overrun_o),
  .noise_o    (noise_o),
  .frame_err_o(frame_err_o),
  .idle_o     (idle_o)
);

// File: tb/os_serial_rx_test.sv
module os_serial_rx_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       rxd = 1'b1;
  logic       tick = 1'b0;
  logic       rx_en = 1'b1;
  logic       nine = 1'b0;
  logic       stat_rd = 1'b0;
  logic       data_rd = 1'b0;
  logic [7:0] data;
  logic       bit8, full, ovr, noise, ferr, idle;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2 clk = ~clk;  // 250 MHz

  os_serial_rx uut (
    .clk_i(clk), .rst_ni(rst_n), .rxd_i(rxd), .tick16_i(tick), .rx_en_i(rx_en),
    .nine_bit_i(nine), .stat_rd_i(stat_rd), .data_rd_i(data_rd),
    .data_o(data), .bit8_o(bit8), .full_o(full), .overrun_o(ovr),
    .noise_o(noise), .frame_err_o(ferr), .idle_o(idle)
  );

  // {nine, stop_ok, glitch bit index (15 = none), 9-bit data}
  localparam int NV = 7;
  localparam logic [14:0] VEC [NV] = '{
    {1'b0, 1'b1, 4'd15, 9'h0A5},
    {1'b0, 1'b1, 4'd3,  9'h03C},
    {1'b1, 1'b1, 4'd15, 9'h1C3},
    {1'b0, 1'b0, 4'd15, 9'h000},
    {1'b1, 1'b1, 4'd0,  9'h0FF},
    {1'b1, 1'b1, 4'd10, 9'h155},
    {1'b0, 1'b0, 4'd8,  9'h0FF}
  };

  task automatic chk(input string req, input logic [8:0] act, input logic [8:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_tick(input logic v);
    rxd = v;
    @(negedge clk) tick = 1'b1;
    @(negedge clk) tick = 1'b0;
    @(negedge clk);
    @(negedge clk);
  endtask

  task automatic send_bit(input logic v, input bit glitch);
    for (int t = 0; t < 16; t++) do_tick((glitch && t == 8) ? !v : v);
  endtask

  task automatic gap(input int n);
    for (int t = 0; t < n; t++) do_tick(1'b1);
  endtask

  task automatic pulse_stat();
    @(negedge clk) stat_rd = 1'b1;
    @(negedge clk) stat_rd = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulse_data();
    @(negedge clk) data_rd = 1'b1;
    @(negedge clk) data_rd = 1'b0;
    @(negedge clk);
  endtask

  task automatic rd_clear();
    pulse_stat();
    pulse_data();
  endtask

  task automatic send_frame(input logic n9, input logic [8:0] d, input logic stop_ok,
                            input int gl, input bit mid_clr);
    int nb;
    nb = n9 ? 9 : 8;
    nine = n9;
    send_bit(1'b0, gl == 0);
    for (int b = 0; b < nb; b++) begin
      if (mid_clr && b == 3) rd_clear();
      send_bit(d[b], gl == b + 1);
    end
    send_bit(stop_ok, gl == nb + 1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [14:0] v;
    logic [8:0]  ed;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R12 reset state
    chk("R12 full", {8'h0, full}, 9'h0);
    chk("R12 flags", {5'h0, ovr, noise, ferr, idle}, 9'h0);
    chk("R12 data", {bit8, data}, 9'h0);
    gap(4);

    // R2 R3 R4 R5 R6 vector table
    for (int i = 0; i < NV; i++) begin
      v = VEC[i];
      send_frame(v[14], v[8:0], v[13], int'(v[12:9]), 1'b0);
      ed = v[14] ? v[8:0] : {1'b0, v[7:0]};
      chk("R2/R3 data", {bit8, data}, ed);
      chk("R4 full", {8'h0, full}, 9'h1);
      chk("R5 noise", {8'h0, noise}, {8'h0, v[12:9] != 4'd15});
      chk("R6 frame_err", {8'h0, ferr}, {8'h0, !v[13]});
      chk("R7 no overrun", {8'h0, ovr}, 9'h0);
      rd_clear();
      chk("R9 cleared", {5'h0, full, noise, ferr, ovr}, 9'h0);
      gap(32);
    end
    nine = 1'b0;

    // R9 single strobes have no effect
    send_frame(1'b0, 9'h05A, 1'b1, 15, 1'b0);
    pulse_data();
    chk("R9 data read alone", {8'h0, full}, 9'h1);
    pulse_stat();
    chk("R9 status read alone", {8'h0, full}, 9'h1);
    pulse_data();
    chk("R9 status then data", {8'h0, full}, 9'h0);
    gap(32);

    // R7 overrun keeps older character
    send_frame(1'b0, 9'h011, 1'b1, 15, 1'b0);
    gap(32);
    send_frame(1'b0, 9'h022, 1'b1, 15, 1'b0);
    chk("R7 overrun set", {8'h0, ovr}, 9'h1);
    chk("R7 old data kept", {1'b0, data}, 9'h011);
    rd_clear();
    chk("R7 overrun cleared", {7'h0, ovr, full}, 9'h0);
    gap(32);

    // R10 clear while next character shifts in
    send_frame(1'b0, 9'h033, 1'b1, 15, 1'b0);
    gap(32);
    send_frame(1'b0, 9'h044, 1'b1, 15, 1'b1);
    chk("R10 new data", {1'b0, data}, 9'h044);
    chk("R10 no overrun", {7'h0, ovr, full}, 9'h1);
    rd_clear();
    gap(32);

    // R1 short start pulse rejected
    for (int t = 0; t < 4; t++) do_tick(1'b0);
    gap(40);
    chk("R1 glitch ignored", {8'h0, full}, 9'h0);
    send_frame(1'b0, 9'h05A, 1'b1, 15, 1'b0);
    chk("R1 next frame data", {1'b0, data}, 9'h05A);
    chk("R1 next frame noise", {8'h0, noise}, 9'h0);
    rd_clear();

    // R8 idle threshold (8-bit: 160 ticks, 6 already in stop bit)
    send_frame(1'b0, 9'h001, 1'b1, 15, 1'b0);
    rd_clear();
    gap(153);
    chk("R8 idle one tick short", {8'h0, idle}, 9'h0);
    gap(1);
    chk("R8 idle at threshold", {8'h0, idle}, 9'h1);
    rd_clear();
    chk("R8 idle cleared", {8'h0, idle}, 9'h0);
    gap(200);
    chk("R8 idle not re-armed", {8'h0, idle}, 9'h0);

    // R11 disabled receiver
    rx_en = 1'b0;
    send_frame(1'b0, 9'h077, 1'b1, 15, 1'b0);
    chk("R11 no reception", {8'h0, full}, 9'h0);
    rx_en = 1'b1;
    gap(32);
    send_frame(1'b0, 9'h0C6, 1'b1, 15, 1'b0);
    chk("R11 re-enabled", {1'b0, data}, 9'h0C6);

    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule